// File: doc/BRIEF.md
# Full/Empty Tagged Scratchpad

A single-port scratchpad of 64-bit words in which every word owns one tag bit that marks it full or empty. One requester issues plain, synchronizing and future-style loads and stores through a valid/ready request channel. Each access returns a success flag and 64 bits of data on a valid/ready response channel one cycle after the request is taken.

A producer and a consumer can use the tag to hand over single words. A synchronizing store fills an empty word, and a synchronizing load drains a full one. Future accesses only proceed on a full word and leave its tag alone. An access whose tag condition does not hold does not wait. It completes at once with a failure flag, and the requester decides when to try again. A tag-initialize command sets or clears the tag of one word and leaves its data alone.

Top module: `fe_spm`

## Requirements
- R1: After reset every tag is empty, `rsp_valid` is low and `req_ready` is high.
- R2: Plain load (op 0) and plain store (op 1) always succeed, ignore the tag and never change it. A plain load returns the stored word, and a plain store writes `req_wdata`.
- R3: A synchronizing load (op 2) on a full word succeeds, returns the word and empties the tag. On an empty word it fails and the tag stays empty.
- R4: A synchronizing store (op 3) on an empty word succeeds, writes the word and fills the tag. On a full word it fails and the tag stays full.
- R5: A future load (op 4) or future store (op 5) succeeds on a full word and fails on an empty word, and never changes the tag. A successful future store writes the word, and a successful future load returns it.
- R6: A failed access returns `rsp_ok` = 0 with zero data and leaves the stored word unchanged. A store of any kind returns zero data.
- R7: Op 6 clears and op 7 sets the tag of the addressed word. Both always succeed and leave the word's data unchanged.
- R8: A response appears the cycle after a request is accepted. It holds its value while `rsp_ready` is low, and `req_ready` stays low until the held response is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_op | input | 3 | Access kind (codes in R2 to R7) |
| req_addr | input | AW (11) | Word address |
| req_wdata | input | 64 | Store data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_ok | output | 1 | 1 = access succeeded |
| rsp_rdata | output | 64 | Load data, zero on failure and for stores |

## Verification
Every result is registered once, so the response to a request taken at edge N is visible from just after edge N and is sampled at the following falling edge. Tag changes take effect at the same edge and are observed through the next request, usually a future load whose success flag exposes the tag. The backpressure scenario holds `rsp_ready` low for two cycles. It checks that `req_ready` is low at each falling edge and that the response is unchanged. It then checks that the queued request is taken at the same edge that drains the old response.

// File: rtl/fe_spm.sv
module fe_spm #(
  parameter int WORDS = 2048,
  parameter int DW    = 64,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic          rsp_ok,
  output logic [DW-1:0] rsp_rdata
);
  logic [DW-1:0] mem [WORDS];
  logic [WORDS-1:0] tag;
  logic accept, full, ok, is_load, is_store, tag_we, tag_nx;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign full      = tag[req_addr];

  always_comb begin
    ok = 1'b1; is_load = 1'b0; is_store = 1'b0; tag_we = 1'b0; tag_nx = 1'b0;
    case (req_op)
      3'd0: is_load = 1'b1;
      3'd1: is_store = 1'b1;
      3'd2: begin is_load = 1'b1;  ok = full;  tag_we = full;  tag_nx = 1'b0; end
      3'd3: begin is_store = 1'b1; ok = !full; tag_we = !full; tag_nx = 1'b1; end
      3'd4: begin is_load = 1'b1;  ok = full; end
      3'd5: begin is_store = 1'b1; ok = full; end
      default: begin tag_we = 1'b1; tag_nx = req_op[0]; end
    endcase
  end

  always_ff @(posedge clk)
    if (accept && is_store && ok) mem[req_addr] <= req_wdata;

  always_ff @(posedge clk)
    if (!rst_n) tag <= '0;
    else if (accept && tag_we) tag[req_addr] <= tag_nx;

  always_ff @(posedge clk)
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_ok    <= 1'b0;
      rsp_rdata <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_ok    <= ok;
      rsp_rdata <= (is_load && ok) ? mem[req_addr] : '0;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
endmodule

// File: rtl/fe_spm_chk.sv
module fe_spm_chk #(
  parameter int DW = 64,
  parameter int AW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [2:0]    req_op,
  input logic [AW-1:0] req_addr,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic          rsp_ok,
  input logic [DW-1:0] rsp_rdata
);
  // R8
  rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);
  // R8
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_ok) && $stable(rsp_rdata));
  // R8
  no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);
  // R6
  fail_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ok |-> rsp_rdata == '0);
  // R2
  plain_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_op[2:1] == 2'b00 |=> rsp_ok);
  // R7
  init_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_op[2:1] == 2'b11 |=> rsp_ok && rsp_rdata == '0);
endmodule

bind fe_spm fe_spm_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_op(req_op), .req_addr(req_addr), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_ok(rsp_ok), .rsp_rdata(rsp_rdata)
);

// File: tb/fe_spm_bench.sv
`timescale 1ns/1ps
module fe_spm_bench;
  localparam int AW = 11;
  localparam logic [2:0] PLD = 0, PST = 1, SLD = 2, SST = 3, FLD = 4, FST = 5, TCLR = 6, TSET = 7;

  logic clk = 0, rst_n = 0, req_valid = 0, rsp_ready = 1;
  logic [2:0] req_op = 0;
  logic [AW-1:0] req_addr = 0;
  logic [63:0] req_wdata = 0;
  logic req_ready, rsp_valid, rsp_ok;
  logic [63:0] rsp_rdata;
  int n_chk = 0, n_bad = 0, cyc = 0;
  logic ok_o;
  logic [63:0] rd_o;

  always #2 clk = ~clk;

  fe_spm u_fe_spm (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_ok(rsp_ok), .rsp_rdata(rsp_rdata));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: act=timeout exp=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(input string req, input logic [64:0] act, input logic [64:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic acc(input logic [2:0] op, input int a, input logic [63:0] d);
    @(negedge clk);
    req_valid = 1; req_op = op; req_addr = AW'(a); req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    check("R8 rsp_valid", {64'd0, rsp_valid}, 65'd1);
    ok_o = rsp_ok; rd_o = rsp_rdata;
  endtask

  task automatic t_reset;
    check("R1 rsp_valid", {64'd0, rsp_valid}, 65'd0);
    check("R1 req_ready", {64'd0, req_ready}, 65'd1);
    acc(FLD, 5, 0);
    check("R1 tag empty", {ok_o, rd_o}, {1'b0, 64'd0});
  endtask

  task automatic t_plain;
    acc(PST, 3, 64'hA5A5_0000_1111_2222);
    check("R2 R6 plain store", {ok_o, rd_o}, {1'b1, 64'd0});
    acc(PLD, 3, 0);
    check("R2 plain load", {ok_o, rd_o}, {1'b1, 64'hA5A5_0000_1111_2222});
    acc(FLD, 3, 0);
    check("R2 tag untouched", {64'd0, ok_o}, 65'd0);
  endtask

  task automatic t_sync;
    acc(SST, 10, 64'h1234);
    check("R4 sync store empty", {ok_o, rd_o}, {1'b1, 64'd0});
    acc(FLD, 10, 0);
    check("R4 R5 now full", {ok_o, rd_o}, {1'b1, 64'h1234});
    acc(SST, 10, 64'hDEAD);
    check("R4 sync store full fails", {ok_o, rd_o}, {1'b0, 64'd0});
    acc(PLD, 10, 0);
    check("R6 no write on fail", {ok_o, rd_o}, {1'b1, 64'h1234});
    acc(SLD, 10, 0);
    check("R3 sync load full", {ok_o, rd_o}, {1'b1, 64'h1234});
    acc(SLD, 10, 0);
    check("R3 R6 sync load empty", {ok_o, rd_o}, {1'b0, 64'd0});
  endtask

  task automatic t_future;
    acc(PST, 20, 64'h7777);
    acc(TSET, 20, 64'hFFFF);
    check("R7 set ok", {ok_o, rd_o}, {1'b1, 64'd0});
    acc(PLD, 20, 0);
    check("R7 data kept", {ok_o, rd_o}, {1'b1, 64'h7777});
    acc(FST, 20, 64'h8888);
    check("R5 future store full", {ok_o, rd_o}, {1'b1, 64'd0});
    acc(FLD, 20, 0);
    check("R5 future load full", {ok_o, rd_o}, {1'b1, 64'h8888});
    acc(FLD, 20, 0);
    check("R5 tag stays full", {64'd0, ok_o}, 65'd1);
    acc(PST, 21, 64'h99);
    acc(FST, 21, 64'h55);
    check("R5 future store empty", {ok_o, rd_o}, {1'b0, 64'd0});
    acc(PLD, 21, 0);
    check("R6 R5 no write", {ok_o, rd_o}, {1'b1, 64'h99});
    acc(TCLR, 20, 0);
    check("R7 clear ok", {64'd0, ok_o}, 65'd1);
    acc(FLD, 20, 0);
    check("R7 cleared", {64'd0, ok_o}, 65'd0);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    rsp_ready = 0; req_valid = 1; req_op = PLD; req_addr = 20; req_wdata = 0;
    @(negedge clk);
    req_op = PLD; req_addr = 21;
    check("R8 first rsp", {rsp_valid, rsp_rdata}, {1'b1, 64'h8888});
    check("R8 ready low", {64'd0, req_ready}, 65'd0);
    @(negedge clk);
    check("R8 held", {rsp_valid, rsp_ok, rsp_rdata[62:0]}, {1'b1, 1'b1, 63'h8888});
    check("R8 still not ready", {64'd0, req_ready}, 65'd0);
    rsp_ready = 1;
    @(negedge clk);
    req_valid = 0;
    check("R8 second rsp", {rsp_valid, rsp_rdata}, {1'b1, 64'h99});
    @(negedge clk);
    check("R8 drained", {64'd0, rsp_valid}, 65'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_sync();
    t_future();
    t_backpressure();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule